// File: doc/BRIEF.md
# NCL Register Ring Stepper

This block is a clock-stepped, synthesizable model of a closed loop of S four-phase NULL Convention Logic register stages with no logic between them. Each stage holds either NULL (every rail low) or a DATA wavefront that carries a small dual-rail tag. One clock edge with `step` high is one step of the model. On that edge, every stage that the handshake rule allows to move copies the state of the stage before it, and all such stages move together.

An initialization port replaces the whole ring with a chosen pattern of DATA and NULL stages. The outputs show the rails of every stage, the number of stages that may move on the next step, a deadlock indication, and a wrapping counter of laps completed by the wavefront whose tag is zero. The block is meant for studying how many wavefronts a ring of a given length can hold, and how many of them can advance at once.

Top module: `ncl_ring`

## Requirements
- R1: Stage k occupies `stage_rails[k*2*TAG_W +: 2*TAG_W]` as TAG_W rail pairs. All rails low means NULL. In a DATA stage every pair is 2'b01 (tag bit 0) or 2'b10 (tag bit 1), and a stage with any rail high counts as DATA. After reset, stage 0 holds DATA with tag 0 (all pairs 2'b01), every other stage is NULL, and `lap_count` is 0.
- R2: Stage k (with p = k-1 and n = k+1, both modulo S) is eligible only when stage k and stage n are both of the opposite kind (DATA or NULL) from stage p. An eligible stage takes the full rails of stage p on a step.
- R3: Eligibility on a step is judged on the ring as it stood before that step, and all eligible stages update on the same edge. While `step` is low, no stage and not the lap counter changes.
- R4: A NULL stage whose successor holds DATA never accepts DATA, so two different DATA wavefronts never become adjacent. A NULL spacer is likewise never removed from between them.
- R5: `adv_count` equals the number of eligible stages in the current ring. A step with no eligible stage changes nothing.
- R6: `deadlock` is high exactly when no stage is eligible. This covers a 2-stage ring, the 4-stage pattern NULL,DATA,NULL,DATA, and rings that are all DATA or all NULL. Stepping a deadlocked ring leaves every stage unchanged.
- R7: `lap_count` increments, wrapping modulo 2^LAP_W, on each step in which stage 0 takes a tag-0 DATA state from stage S-1. A tag-1 wavefront entering stage 0 does not count.
- R8: While `load` is high, every stage takes `load_rails` on the next edge and `lap_count` clears to 0. This has priority over `step`.
- R9: A 5-stage ring holding four states (two DATA, two NULL) allows only one stage to move per step. It returns to the same pattern after the wavefronts have circulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one rising edge with `step` high is one model step |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Replace the ring contents with `load_rails` |
| load_rails | input | S*2*TAG_W | Pattern to load, stage 0 in the low bits |
| step | input | 1 | Advance all eligible stages on this edge |
| stage_rails | output | S*2*TAG_W | Current rails of every stage |
| adv_count | output | $clog2(S+1) | Number of stages eligible to move now |
| deadlock | output | 1 | High when no stage is eligible |
| lap_count | output | LAP_W | Laps completed by the tag-0 wavefront |

## Verification
The bench drives a full odd ring holding a tag-0 and a tag-1 wavefront one step at a time and compares each pattern against a hand-worked trace. A design that judged eligibility on its predecessor alone would merge the two wavefronts, and one that updated stages in sequence within a step would move a wavefront two places at once. Deadlocked patterns are stepped in 2-, 4- and 5-stage rings; a design that ignored the successor test would move state in them. The lap counter is driven past its wrap point and fed tag-1 arrivals; a design that did not decode the tag, or lost the carry, would give a wrong count.

// File: rtl/ncl_ring.sv
module ncl_ring #(
  parameter int S     = 5,
  parameter int TAG_W = 1,
  parameter int LAP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [S*2*TAG_W-1:0]     load_rails,
  input  logic                     step,
  output logic [S*2*TAG_W-1:0]     stage_rails,
  output logic [$clog2(S+1)-1:0]   adv_count,
  output logic                     deadlock,
  output logic [LAP_W-1:0]         lap_count
);
  localparam int RW = 2 * TAG_W;
  localparam int CW = $clog2(S + 1);
  localparam logic [RW-1:0] TAG0 = {TAG_W{2'b01}};

  logic [RW-1:0] st [S];
  logic [S-1:0]  is_data;
  logic [S-1:0]  elig;
  logic [CW-1:0] cnt;
  logic [LAP_W-1:0] lap_q;

  for (genvar i = 0; i < S; i++) begin : g_stage
    localparam int P = (i + S - 1) % S;
    localparam int N = (i + 1) % S;
    localparam logic [RW-1:0] INIT = (i == 0) ? TAG0 : '0;

    assign is_data[i] = |st[i];
    assign elig[i]    = (is_data[i] != is_data[P]) && (is_data[N] != is_data[P]);
    assign stage_rails[i*RW +: RW] = st[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              st[i] <= INIT;
      else if (load)           st[i] <= load_rails[i*RW +: RW];
      else if (step && elig[i]) st[i] <= st[P];
    end
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < S; k++) cnt = cnt + CW'(elig[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    lap_q <= '0;
    else if (load)                                 lap_q <= '0;
    else if (step && elig[0] && st[S-1] == TAG0)   lap_q <= lap_q + 1'b1;
  end

  assign adv_count = cnt;
  assign deadlock  = ~|elig;
  assign lap_count = lap_q;
endmodule

// File: rtl/ncl_ring_chk.sv
module ncl_ring_chk #(
  parameter int S     = 5,
  parameter int TAG_W = 1,
  parameter int LAP_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     load,
  input logic [S*2*TAG_W-1:0]     load_rails,
  input logic                     step,
  input logic [S*2*TAG_W-1:0]     stage_rails,
  input logic [$clog2(S+1)-1:0]   adv_count,
  input logic                     deadlock,
  input logic [LAP_W-1:0]         lap_count
);
  localparam int RW = 2 * TAG_W;

  for (genvar i = 0; i < S; i++) begin : g_chk
    localparam int P = (i + S - 1) % S;
    localparam int N = (i + 1) % S;

    assert_copy_pred_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step) |=>
        (stage_rails[i*RW +: RW] == $past(stage_rails[i*RW +: RW]) ||
         stage_rails[i*RW +: RW] == $past(stage_rails[P*RW +: RW])));

    assert_no_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step && !(|stage_rails[i*RW +: RW]) && (|stage_rails[N*RW +: RW]))
        |=> $stable(stage_rails[i*RW +: RW]));
  end

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(stage_rails) && $stable(lap_count)));

  assert_zero_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_count == '0) |=> $stable(stage_rails));

  assert_deadlock_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && deadlock) |=> $stable(stage_rails));

  assert_lap_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (lap_count == $past(lap_count) || lap_count == $past(lap_count) + 1'b1));

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (stage_rails == $past(load_rails) && lap_count == '0));
endmodule

bind ncl_ring ncl_ring_chk #(.S(S), .TAG_W(TAG_W), .LAP_W(LAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .load_rails(load_rails), .step(step),
  .stage_rails(stage_rails), .adv_count(adv_count), .deadlock(deadlock),
  .lap_count(lap_count)
);

// File: tb/tb_ncl_ring.sv
module tb_ncl_ring;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       load = 1'b0, step = 1'b0;
  logic [9:0] load_rails = '0;
  logic [9:0] rails;
  logic [2:0] adv;
  logic       dl;
  logic [7:0] lap;

  ncl_ring #(.S(5), .TAG_W(1), .LAP_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_rails(load_rails), .step(step),
    .stage_rails(rails), .adv_count(adv), .deadlock(dl), .lap_count(lap));

  logic       s2_step = 1'b0;
  logic [3:0] r2;
  logic [1:0] a2;
  logic       d2;
  logic [7:0] l2;
  ncl_ring #(.S(2), .TAG_W(1), .LAP_W(8)) dut2 (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .load_rails(4'h0), .step(s2_step),
    .stage_rails(r2), .adv_count(a2), .deadlock(d2), .lap_count(l2));

  logic       s4_load = 1'b0, s4_step = 1'b0;
  logic [7:0] s4_pat = '0;
  logic [7:0] r4;
  logic [2:0] a4;
  logic       d4;
  logic [7:0] l4;
  ncl_ring #(.S(4), .TAG_W(1), .LAP_W(8)) dut4 (
    .clk(clk), .rst_n(rst_n), .load(s4_load), .load_rails(s4_pat), .step(s4_step),
    .stage_rails(r4), .adv_count(a4), .deadlock(d4), .lap_count(l4));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic do_load(input logic [9:0] p);
    @(negedge clk); load = 1'b1; load_rails = p;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_steps(input int n);
    if (n > 0) begin
      step = 1'b1;
      repeat (n) @(negedge clk);
      step = 1'b0;
    end
  endtask

  // Stage codes: NULL=00, tag0 DATA=01, tag1 DATA=10; stage 0 in bits [1:0].
  localparam int NV = 11;
  localparam logic [9:0] LD [NV] = '{10'h204, 10'h204, 10'h021, 10'h021, 10'h021,
                                     10'h021, 10'h021, 10'h155, 10'h000, 10'h200, 10'h100};
  localparam int         NS [NV] = '{0, 1, 1, 2, 3, 5, 6, 3, 2, 1, 1};
  localparam logic [9:0] EX [NV] = '{10'h204, 10'h214, 10'h0A1, 10'h081, 10'h085,
                                     10'h284, 10'h204, 10'h155, 10'h000, 10'h202, 10'h101};
  localparam int         AV [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 2, 2};
  localparam bit         DL [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0};
  localparam int         LP [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1};
  localparam string      RQ [NV] = '{"R9", "R9", "R4", "R4", "R4", "R2", "R9",
                                     "R6", "R6", "R7", "R7"};

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset rails", int'(rails), 'h001);
    check("R1", "reset lap", int'(lap), 0);
    check("R5", "reset adv", int'(adv), 1);
    check("R6", "reset deadlock", int'(dl), 0);

    // R3 two stages move together on one step
    do_steps(1);
    check("R3", "step1 rails", int'(rails), 'h005);
    check("R5", "step1 adv", int'(adv), 2);
    do_steps(1);
    check("R3", "step2 rails", int'(rails), 'h014);
    repeat (3) @(negedge clk);
    check("R3", "idle rails", int'(rails), 'h014);
    do_steps(13);
    check("R7", "lap after 15 steps", int'(lap), 3);
    check("R2", "rails after 15 steps", int'(rails), 'h101);

    // R8 load wins over step and clears lap
    @(negedge clk); load = 1'b1; step = 1'b1; load_rails = 10'h204;
    @(negedge clk); load = 1'b0; step = 1'b0;
    check("R8", "load over step rails", int'(rails), 'h204);
    check("R8", "load clears lap", int'(lap), 0);

    for (int v = 0; v < NV; v++) begin
      do_load(LD[v]);
      do_steps(NS[v]);
      check(RQ[v], $sformatf("vec%0d rails", v), int'(rails), int'(EX[v]));
      check("R5", $sformatf("vec%0d adv", v), int'(adv), AV[v]);
      check("R6", $sformatf("vec%0d deadlock", v), int'(dl), int'(DL[v]));
      check("R7", $sformatf("vec%0d lap", v), int'(lap), LP[v]);
    end

    // R7 wrap: reset pattern, 1284 steps -> 256 laps -> 0
    do_load(10'h001);
    do_steps(1284);
    check("R7", "lap wrap", int'(lap), 0);
    check("R7", "wrap rails", int'(rails), 'h140);
    do_steps(1);
    check("R7", "lap after wrap", int'(lap), 1);

    // R6 two-stage ring deadlocks
    check("R6", "S2 deadlock", int'(d2), 1);
    check("R6", "S2 adv", int'(a2), 0);
    s2_step = 1'b1; repeat (3) @(negedge clk); s2_step = 1'b0;
    check("R6", "S2 rails frozen", int'(r2), 'h1);

    // R6 four-stage N,A,N,B deadlock
    @(negedge clk); s4_load = 1'b1; s4_pat = 8'h84;
    @(negedge clk); s4_load = 1'b0;
    check("R6", "S4 alternating deadlock", int'(d4), 1);
    s4_step = 1'b1; repeat (2) @(negedge clk); s4_step = 1'b0;
    check("R6", "S4 alternating frozen", int'(r4), 'h84);

    // R5 four-stage N,A,A,N: two movers
    @(negedge clk); s4_load = 1'b1; s4_pat = 8'h14;
    @(negedge clk); s4_load = 1'b0;
    check("R5", "S4 pair adv", int'(a4), 2);
    s4_step = 1'b1; @(negedge clk); s4_step = 1'b0;
    check("R3", "S4 pair step", int'(r4), 'h50);

    report();
  end
endmodule